// File: doc/BRIEF.md
# Audio Sample Queue Pair with Threshold Requests

This block sits between a processor-facing register port and an audio serializer. It holds two word queues. Words the processor writes wait in the transmit queue until the serializer takes them. Words the serializer delivers wait in the receive queue until the processor reads them. Each queue reports its fill level and raises a request flag when a programmable threshold is crossed. Four sticky error flags record pushes into a full queue and pops from an empty one. Software clears each flag by writing 0 to it.

Word formatting is applied on the way through. Samples can be placed at the high end or the low end of the 32-bit processor word. An optional byte reversal reorders the four bytes. The serializer side always sees samples at the high end. Each queue has its own hold-in-reset input, and a global soft reset clears both queues and all error flags. Everything runs on one clock.

Top module: `afifo_top`

## Requirements
- R1: After reset, both counts are 0, `tx_req` = 1, `rx_req` = 0, `idle` = 1 and `err_flags` = 0.
- R2: Each queue holds up to 32 words. Words leave in the order they entered, and `rx_count`/`tx_count` give the number of stored words (0..32) from the cycle after each accepted push or pop.
- R3: `rx_req` is 1 exactly when `rx_count` >= `cfg_rx_thr` + 1.
- R4: `tx_req` is 1 exactly when (32 - `tx_count`) >= `cfg_tx_thr` + 1.
- R5: A push into a full queue is dropped and leaves the count at 32. It sets the overflow flag: `err_flags` bit 0 for the receive queue, bit 2 for the transmit queue.
- R6: The data output of an empty queue reads 0. A pop from an empty queue sets the underflow flag: bit 1 for the receive queue, bit 3 for the transmit queue.
- R7: While `err_clr_we` = 1, every `err_flags` bit whose `err_clr_data` bit is 0 is cleared, and bits written 1 are kept. An error event in the same cycle as its clear leaves the flag set.
- R8: `irq_rx` = `rx_req` & `cfg_rx_ie`, `irq_tx` = `tx_req` & `cfg_tx_ie`, and `irq_err` = 1 when any flag bit is set whose `cfg_err_ie` bit is also set.
- R9: While `cfg_rx_hold` or `cfg_tx_hold` is 1, that queue is empty, its pushes and pops are ignored, and no error flag is set for it.
- R10: `cfg_soft_rst` = 1 empties both queues and clears all error flags.
- R11: `cfg_wlen` selects the sample width: 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits. With `cfg_rjust` = 1, transmit words are shifted left by (32 - width) toward the serializer, and receive words are shifted right by (32 - width) with zero fill toward the processor. With `cfg_rjust` = 0, words pass through unshifted.
- R12: With `cfg_swap` = 1, bytes are reversed: {b0,b1,b2,b3}. The transmit path reverses before shifting, and the receive path reverses after shifting.
- R13: `idle` is 1 exactly when both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Processor push into the transmit queue |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rd | input | 1 | Processor pop from the receive queue |
| cpu_rdata | output | 32 | Formatted head of the receive queue, 0 when empty |
| ser_push | input | 1 | Serializer push into the receive queue |
| ser_wdata | input | 32 | Serializer word, sample at the high end |
| ser_pop | input | 1 | Serializer pop from the transmit queue |
| ser_tdata | output | 32 | Formatted head of the transmit queue, 0 when empty |
| cfg_rx_thr | input | 5 | Receive request threshold |
| cfg_tx_thr | input | 5 | Transmit request threshold |
| cfg_rx_hold | input | 1 | Hold the receive queue in reset |
| cfg_tx_hold | input | 1 | Hold the transmit queue in reset |
| cfg_soft_rst | input | 1 | Global soft reset |
| cfg_swap | input | 1 | Byte reversal enable |
| cfg_rjust | input | 1 | Samples sit at the low end of the processor word |
| cfg_wlen | input | 2 | Sample width code |
| cfg_rx_ie | input | 1 | Receive request interrupt enable |
| cfg_tx_ie | input | 1 | Transmit request interrupt enable |
| cfg_err_ie | input | 4 | Per-flag error interrupt enables |
| err_clr_we | input | 1 | Error flag write strobe |
| err_clr_data | input | 4 | Error flag write value (0 clears) |
| rx_count | output | 6 | Stored receive words |
| tx_count | output | 6 | Stored transmit words |
| rx_req | output | 1 | Receive threshold request |
| tx_req | output | 1 | Transmit threshold request |
| idle | output | 1 | Both queues empty |
| err_flags | output | 4 | Sticky errors: bit 0 rx overflow, bit 1 rx underflow, bit 2 tx overflow, bit 3 tx underflow |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The threshold logic is swept over every fill level from 0 to 32 against all 32 threshold values, for both queues. An off-by-one in the compare, or a mix-up between free space and stored count, shows up at the exact boundary level.

The queues are filled with distinct incrementing words and then drained, which exposes ordering or pointer-wrap faults. The fill and drain are followed by a push into a full queue and a pop from an empty one, so that each error bit is seen landing at its own position.

The formatter is swept over all 16 combinations of width, placement and byte reversal, in both directions. The test words have unequal bytes, so a wrong shift amount and a wrong byte order give different results.

The error flags are checked under three clear patterns: a selective clear, a clear colliding with a new event, and a clear of every flag. These patterns tell apart clear-wins, write-1 polarity and bit misrouting.

// File: rtl/afifo_pkg.sv
// Shared constants and helpers for the audio queue pair.
// Assumes 32-bit data words and byte-granular sample widths.
package afifo_pkg;
    localparam int DATA_W = 32;
    localparam int ERR_N  = 4;

    // Bit positions of the sticky error flags
    localparam int ERR_RX_OVF = 0;
    localparam int ERR_RX_UNF = 1;
    localparam int ERR_TX_OVF = 2;
    localparam int ERR_TX_UNF = 3;

    // Reverse the four bytes of a word
    function automatic logic [DATA_W-1:0] byte_rev(input logic [DATA_W-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Shift distance (32 - width) for width code 0..3 = 8..32 bits
    function automatic logic [4:0] pad_bits(input logic [1:0] wlen);
        return {~wlen, 3'b000};
    endfunction
endpackage

// File: rtl/afifo_queue.sv
// Synchronous word queue with fill count and error pulses.
// Assumes DEPTH is a power of two. The flush input empties the queue
// and blocks all traffic. An empty queue presents zero on rdata.
module afifo_queue #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          unf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_push, do_pop;

    // Accept decisions, taken on the count at the start of the cycle
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        ovf     = push && full && !flush;
        unf     = pop && empty && !flush;
        rdata   = empty ? '0 : mem[rd_ptr];
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == FULL_CNT && !flush) |=> count == FULL_CNT);
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/afifo_fmt.sv
// Word formatter between the processor layout and the serializer layout.
// RX_DIR=0: processor word -> optional byte reversal -> left shift.
// RX_DIR=1: serializer word -> right shift with zero fill -> optional reversal.
module afifo_fmt
    import afifo_pkg::*;
#(
    parameter bit RX_DIR = 1'b0
) (
    input  logic [DATA_W-1:0] din,
    input  logic              swap,
    input  logic              rjust,
    input  logic [1:0]        wlen,
    output logic [DATA_W-1:0] dout
);
    logic [4:0] sh;
    assign sh = pad_bits(wlen);

    generate
        if (RX_DIR) begin : g_rx
            logic [DATA_W-1:0] aligned;
            // Move the sample down, then reorder bytes
            always_comb begin
                aligned = rjust ? (din >> sh) : din;
                dout    = swap ? byte_rev(aligned) : aligned;
            end
        end else begin : g_tx
            logic [DATA_W-1:0] ordered;
            // Reorder bytes, then move the sample up
            always_comb begin
                ordered = swap ? byte_rev(din) : din;
                dout    = rjust ? (ordered << sh) : ordered;
            end
        end
    endgenerate
endmodule

// File: rtl/afifo_errs.sv
// Sticky error flags: set by event pulses, cleared by writing 0.
// An event in the same cycle as its clear wins; soft reset clears all.
module afifo_errs #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // One sticky bit
            always_ff @(posedge clk) begin
                if (!rst_n || srst)              flags[i] <= 1'b0;
                else if (evt[i])                 flags[i] <= 1'b1;
                else if (clr_we && !clr_data[i]) flags[i] <= 1'b0;
            end

            a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[i] && !srst) |=> flags[i]);
            a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && !clr_data[i] && !evt[i]) |=> !flags[i]);
        end
    endgenerate
endmodule

// File: rtl/afifo_top.sv
// Audio queue pair: transmit and receive queues, threshold requests,
// sticky errors and word formatting. Single clock; DEPTH a power of two.
module afifo_top
    import afifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = TW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ser_push,
    input  logic [DATA_W-1:0] ser_wdata,
    input  logic              ser_pop,
    output logic [DATA_W-1:0] ser_tdata,
    input  logic [TW-1:0]     cfg_rx_thr,
    input  logic [TW-1:0]     cfg_tx_thr,
    input  logic              cfg_rx_hold,
    input  logic              cfg_tx_hold,
    input  logic              cfg_soft_rst,
    input  logic              cfg_swap,
    input  logic              cfg_rjust,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_rx_ie,
    input  logic              cfg_tx_ie,
    input  logic [ERR_N-1:0]  cfg_err_ie,
    input  logic              err_clr_we,
    input  logic [ERR_N-1:0]  err_clr_data,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count,
    output logic              rx_req,
    output logic              tx_req,
    output logic              idle,
    output logic [ERR_N-1:0]  err_flags,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_err
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] rx_head, tx_head, tx_in;
    logic              rx_ovf, rx_unf, tx_ovf, tx_unf;
    logic [ERR_N-1:0]  evt;
    logic [CW-1:0]     tx_free;

    // Processor words are stored raw; formatting is applied at the serializer
    assign tx_in = cpu_wdata;

    afifo_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(cfg_rx_hold || cfg_soft_rst),
        .push(ser_push), .wdata(ser_wdata), .pop(cpu_rd),
        .rdata(rx_head), .count(rx_count), .ovf(rx_ovf), .unf(rx_unf));

    afifo_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(cfg_tx_hold || cfg_soft_rst),
        .push(cpu_wr), .wdata(tx_in), .pop(ser_pop),
        .rdata(tx_head), .count(tx_count), .ovf(tx_ovf), .unf(tx_unf));

    afifo_fmt #(.RX_DIR(1'b1)) u_rxfmt (
        .din(rx_head), .swap(cfg_swap), .rjust(cfg_rjust), .wlen(cfg_wlen),
        .dout(cpu_rdata));

    afifo_fmt #(.RX_DIR(1'b0)) u_txfmt (
        .din(tx_head), .swap(cfg_swap), .rjust(cfg_rjust), .wlen(cfg_wlen),
        .dout(ser_tdata));

    // Gather error pulses into flag positions
    always_comb begin
        evt             = '0;
        evt[ERR_RX_OVF] = rx_ovf;
        evt[ERR_RX_UNF] = rx_unf;
        evt[ERR_TX_OVF] = tx_ovf;
        evt[ERR_TX_UNF] = tx_unf;
    end

    afifo_errs #(.N(ERR_N)) u_errs (
        .clk(clk), .rst_n(rst_n), .srst(cfg_soft_rst), .evt(evt),
        .clr_we(err_clr_we), .clr_data(err_clr_data), .flags(err_flags));

    // Threshold requests, idle status and interrupt gating
    always_comb begin
        tx_free = FULL_CNT - tx_count;
        rx_req  = rx_count > {1'b0, cfg_rx_thr};
        tx_req  = tx_free > {1'b0, cfg_tx_thr};
        idle    = (rx_count == '0) && (tx_count == '0);
        irq_rx  = rx_req && cfg_rx_ie;
        irq_tx  = tx_req && cfg_tx_ie;
        irq_err = |(err_flags & cfg_err_ie);
    end

    a_r13_idle_has_tx_room: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> tx_req);
    a_r6_empty_rx_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> cpu_rdata == '0);
    a_r6_empty_tx_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> ser_tdata == '0);
    a_r10_soft_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft_rst |=> (err_flags == '0 && idle));
endmodule

// File: tb/sim_afifo_top.sv
module sim_afifo_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 0, cpu_rd = 0, ser_push = 0, ser_pop = 0;
    logic [31:0] cpu_wdata = 0, ser_wdata = 0;
    logic [31:0] cpu_rdata, ser_tdata;
    logic [4:0]  cfg_rx_thr = 0, cfg_tx_thr = 0;
    logic        cfg_rx_hold = 0, cfg_tx_hold = 0, cfg_soft_rst = 0;
    logic        cfg_swap = 0, cfg_rjust = 0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic        cfg_rx_ie = 0, cfg_tx_ie = 0;
    logic [3:0]  cfg_err_ie = 0;
    logic        err_clr_we = 0;
    logic [3:0]  err_clr_data = 4'hF;
    logic [5:0]  rx_count, tx_count;
    logic        rx_req, tx_req, idle, irq_rx, irq_tx, irq_err;
    logic [3:0]  err_flags;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    afifo_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_rx(input logic [31:0] d);
        ser_wdata = d; ser_push = 1; tick(); ser_push = 0;
    endtask

    task automatic push_tx(input logic [31:0] d);
        cpu_wdata = d; cpu_wr = 1; tick(); cpu_wr = 0;
    endtask

    function automatic logic [31:0] rev(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] exp_tx(input logic [31:0] d, input int w, input bit rj, input bit sw);
        logic [31:0] s;
        s = sw ? rev(d) : d;
        return rj ? (s << (24 - 8 * w)) : s;
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] d, input int w, input bit rj, input bit sw);
        logic [31:0] a;
        a = rj ? (d >> (24 - 8 * w)) : d;
        return sw ? rev(a) : a;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 idle", idle, 1);
        chk("R1 err_flags", err_flags, 0);

        // R3/R8 receive threshold sweep over every fill level
        for (int n = 0; n <= 32; n++) begin
            chk("R2 rx_count", rx_count, n);
            chk("R13 idle", idle, n == 0);
            for (int t = 0; t < 32; t++) begin
                cfg_rx_thr = 5'(t);
                cfg_rx_ie  = t[0];
                #1;
                chk("R3 rx_req", rx_req, n >= t + 1);
                chk("R8 irq_rx", irq_rx, (n >= t + 1) && t[0]);
            end
            if (n < 32) push_rx(32'h1000 + n);
        end
        // R5 receive overflow
        push_rx(32'hDEAD);
        chk("R5 rx_count full", rx_count, 32);
        chk("R5 rx overflow flag", err_flags, 4'b0001);
        cfg_err_ie = 4'b0001; #1;
        chk("R8 irq_err enabled", irq_err, 1);
        cfg_err_ie = 4'b0010; #1;
        chk("R8 irq_err masked", irq_err, 0);
        cfg_err_ie = 0;

        // R2 drain in order
        for (int i = 0; i < 32; i++) begin
            chk("R2 rx order", cpu_rdata, 32'h1000 + i);
            cpu_rd = 1; tick(); cpu_rd = 0;
            chk("R2 rx_count drain", rx_count, 31 - i);
        end
        // R6 receive underflow
        chk("R6 empty rx data", cpu_rdata, 0);
        cpu_rd = 1; tick(); cpu_rd = 0;
        chk("R6 rx underflow flag", err_flags, 4'b0011);

        // R7 selective clear, collision, full clear
        err_clr_we = 1; err_clr_data = 4'b1110; tick();
        chk("R7 selective clear", err_flags, 4'b0010);
        err_clr_data = 4'b1101; cpu_rd = 1; tick(); cpu_rd = 0;
        chk("R7 event wins over clear", err_flags, 4'b0010);
        err_clr_data = 4'b0000; tick();
        chk("R7 clear all", err_flags, 0);
        err_clr_we = 0; err_clr_data = 4'hF;

        // R4/R8 transmit threshold sweep
        for (int n = 0; n <= 32; n++) begin
            chk("R2 tx_count", tx_count, n);
            for (int t = 0; t < 32; t++) begin
                cfg_tx_thr = 5'(t);
                cfg_tx_ie  = ~t[1];
                #1;
                chk("R4 tx_req", tx_req, (32 - n) >= t + 1);
                chk("R8 irq_tx", irq_tx, ((32 - n) >= t + 1) && !t[1]);
            end
            if (n < 32) push_tx(32'hA000 + n);
        end
        push_tx(32'hBEEF);
        chk("R5 tx_count full", tx_count, 32);
        chk("R5 tx overflow flag", err_flags, 4'b0100);
        for (int i = 0; i < 32; i++) begin
            chk("R2 tx order", ser_tdata, 32'hA000 + i);
            ser_pop = 1; tick(); ser_pop = 0;
        end
        chk("R6 empty tx data", ser_tdata, 0);
        ser_pop = 1; tick(); ser_pop = 0;
        chk("R6 tx underflow flag", err_flags, 4'b1100);
        err_clr_we = 1; err_clr_data = 0; tick(); err_clr_we = 0; err_clr_data = 4'hF;

        // R9 queue hold
        push_rx(1); push_rx(2); push_rx(3);
        chk("R9 before hold", rx_count, 3);
        cfg_rx_hold = 1; tick();
        chk("R9 hold empties", rx_count, 0);
        push_rx(4);
        chk("R9 push ignored", rx_count, 0);
        cpu_rd = 1; tick(); cpu_rd = 0;
        chk("R9 no flags under hold", err_flags, 0);
        cfg_rx_hold = 0;
        push_tx(5);
        cfg_tx_hold = 1; tick();
        chk("R9 tx hold empties", tx_count, 0);
        push_tx(6);
        chk("R9 tx push ignored", tx_count, 0);
        chk("R9 tx no overflow", err_flags, 0);
        cfg_tx_hold = 0; tick();

        // R10 soft reset
        push_tx(7); push_rx(8);
        cpu_rd = 1; tick(); cpu_rd = 1; tick(); cpu_rd = 0;
        chk("R10 flag before", err_flags, 4'b0010);
        push_rx(9);
        cfg_soft_rst = 1; tick(); cfg_soft_rst = 0;
        chk("R10 tx_count", tx_count, 0);
        chk("R10 rx_count", rx_count, 0);
        chk("R10 flags", err_flags, 0);

        // R11/R12 formatting sweep
        for (int w = 0; w < 4; w++)
            for (int rj = 0; rj < 2; rj++)
                for (int sw = 0; sw < 2; sw++) begin
                    cfg_wlen = 2'(w); cfg_rjust = rj[0]; cfg_swap = sw[0];
                    push_tx(32'h89ABCDEF);
                    chk("R11 R12 tx format", ser_tdata, exp_tx(32'h89ABCDEF, w, rj[0], sw[0]));
                    ser_pop = 1; tick(); ser_pop = 0;
                    push_rx(32'hF1E2D3C4);
                    chk("R11 R12 rx format", cpu_rdata, exp_rx(32'hF1E2D3C4, w, rj[0], sw[0]));
                    cpu_rd = 1; tick(); cpu_rd = 0;
                end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule